// File: doc/BRIEF.md
# LRU Stack-Distance Utility Monitor

The block watches the access stream of one core into a shared set-associative cache and estimates how useful each additional way of that cache would be to the core. It holds a small shadow tag directory that mirrors only a sampled subset of the cache sets. On that directory it runs exact least-recently-used ordering, independent of what the real cache does. When an access hits in the shadow directory, the block notes how deep in the recency order the line sat and increments the counter for that depth.

Because LRU is a stack algorithm, a core given n ways would have hit on exactly the accesses whose depth was below n. Summing the first n counters therefore gives the hit count for an n-way allocation, and one pass over the stream yields that figure for every n at once. A partitioning engine outside this block reads the counters periodically. It can pulse a decay input that halves every counter, so older behaviour fades.

A set is sampled when the low index bits below the top five are all zero. That gives 32 sampled sets spread at an even stride, and each maps to a directory slot given by the top five index bits. Accesses to every other set are dropped.

Top module: `lru_utility_monitor`

## Requirements
- R1: After reset every counter reads zero and every shadow entry is invalid, so the first access to any sampled set is a miss.
- R2: A set is sampled only when acc_set bits [SET_W-6:0] are all zero; its slot is acc_set[SET_W-1:SET_W-5]. An access to any other set changes neither the counters nor the shadow directory.
- R3: A shadow hit at recency depth p (0 = most recent, 15 = least recent) adds one to counter p only. Counter p is output on hit_cnt[p*CNT_W +: CNT_W], and the new value shows in the cycle after the clock edge that took the access.
- R4: On a hit at depth p, the line moves to depth 0, lines at depths 0..p-1 each move one deeper, and lines deeper than p keep their depth.
- R5: On a shadow miss the new tag takes depth 0, every other line moves one deeper, the line at depth 15 is dropped, and no counter changes.
- R6: Invalid entries are used before any valid entry is dropped: 16 distinct tags sent to one sampled set all stay resident (the first of them then hits at depth 15), and a 17th distinct tag drops the oldest.
- R7: Each sampled set keeps its own recency order; a tag resident in one slot does not hit when it is sent to another slot.
- R8: A counter at 2^CNT_W-1 stays there on further hits.
- R9: A cycle with decay high and no hit replaces every counter by its value shifted right by one (rounded down).
- R10: When decay and a hit at depth p arrive in the same cycle, counter p becomes its halved value plus one, and every other counter is halved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Core access strobe, one access per cycle |
| acc_set | input | SET_W | Cache set index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| decay | input | 1 | Halve all counters in this cycle |
| hit_cnt | output | WAYS*CNT_W | Per-depth hit counters, depth p at bits [p*CNT_W +: CNT_W] |

## Verification
On every cycle the assertions check several properties. Resident tags within a set stay unique. An accepted access leaves its tag at depth 0. Unsampled or idle cycles leave the directory untouched, and misses leave the counters untouched. A hit raises its counter by exactly one, saturated counters hold, and decay halves. The exact depth at which a given line hits depends on the history of a whole set, so only the bench's access sequences can show it. These sequences cover reordering after hits at several depths, filling a set to 16 and evicting the oldest line, slot independence, and the directory being cleared by a reset in the middle of a run.

// File: rtl/lru_umon_pkg.sv
package lru_umon_pkg;

    // Number of index bits that pick a sampled set: 2**5 = 32 shadow slots.
    localparam int unsigned UMON_SLOT_W = 5;

    // Outcome of one cycle as seen by the shadow directory.
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_SKIP = 2'd1,
        ACC_MISS = 2'd2,
        ACC_HIT  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/lru_umon_sampler.sv
module lru_umon_sampler #(
    parameter int unsigned SET_W  = 11,
    parameter int unsigned SLOT_W = 5
) (
    input  logic [SET_W-1:0]  set_idx,
    output logic              sampled,
    output logic [SLOT_W-1:0] slot
);
    localparam int unsigned SKIP_W = SET_W - SLOT_W;

    assign slot = set_idx[SET_W-1 -: SLOT_W];

    generate
        if (SKIP_W == 0) begin : g_all_sets
            assign sampled = 1'b1;
        end else begin : g_strided
            assign sampled = (set_idx[SKIP_W-1:0] == '0);
        end
    endgenerate

endmodule

// File: rtl/lru_umon_shadow_dir.sv
module lru_umon_shadow_dir
    import lru_umon_pkg::*;
#(
    parameter int unsigned WAYS   = 16,
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SLOT_W = 5,
    parameter int unsigned POS_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              sampled,
    input  logic [SLOT_W-1:0] slot,
    input  logic [TAG_W-1:0]  tag,
    output acc_kind_e         kind,
    output logic [POS_W-1:0]  hit_pos
);
    localparam int unsigned SETS = 1 << SLOT_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } line_t;

    // Row element w holds the line at recency depth w (0 = most recent).
    typedef line_t [WAYS-1:0] row_t;

    typedef struct packed {
        row_t [SETS-1:0] rows;
    } dir_state_t;

    dir_state_t       st_d, st_q;
    row_t             cur_row;
    row_t             new_row;
    logic [WAYS-1:0]  match;
    logic             hit_any;

    always_comb begin
        cur_row = st_q.rows[slot];

        match = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = cur_row[w].vld && (cur_row[w].tag == tag);
        end
        hit_any = |match;

        hit_pos = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_pos = POS_W'(w);
        end

        // Depth 0 always receives the accessed tag; lines above the hit
        // depth (or all lines on a miss) slide one step deeper.
        new_row    = cur_row;
        new_row[0] = {1'b1, tag};
        for (int w = 1; w < WAYS; w++) begin
            if (!hit_any || (w <= int'(hit_pos))) begin
                new_row[w] = cur_row[w-1];
            end
        end

        st_d = st_q;
        if (acc_valid && sampled) begin
            st_d.rows[slot] = new_row;
        end

        if (!acc_valid)    kind = ACC_IDLE;
        else if (!sampled) kind = ACC_SKIP;
        else if (hit_any)  kind = ACC_HIT;
        else               kind = ACC_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a tag is never resident twice in one set.
    p_tag_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R4: an accepted access leaves its tag valid at depth 0 of its slot.
    p_mru_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sampled) |=>
            (st_q.rows[$past(slot)][0] == {1'b1, $past(tag)}));

    // R2: unsampled or idle cycles leave the directory untouched.
    p_ignore_unsampled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || !sampled) |=> $stable(st_q));

endmodule

// File: rtl/lru_umon_hit_counters.sv
module lru_umon_hit_counters #(
    parameter int unsigned WAYS  = 16,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned POS_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_en,
    input  logic [POS_W-1:0]      inc_pos,
    input  logic                  decay,
    output logic [WAYS*CNT_W-1:0] cnt_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WAYS-1:0][CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WAYS; i++) begin
            logic [CNT_W-1:0] base;
            base = decay ? (st_q.cnt[i] >> 1) : st_q.cnt[i];
            if (inc_en && (inc_pos == POS_W'(i)) && (base != CNT_MAX)) begin
                base = base + CNT_W'(1);
            end
            st_d.cnt[i] = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_flat = st_q.cnt;

    generate
        for (genvar i = 0; i < WAYS; i++) begin : g_chk
            // R8: a saturated counter holds while no decay arrives.
            p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ((st_q.cnt[i] == CNT_MAX) && !decay) |=> (st_q.cnt[i] == CNT_MAX));

            // R3: a hit below saturation adds exactly one.
            p_hit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_en && (inc_pos == POS_W'(i)) && !decay && (st_q.cnt[i] != CNT_MAX))
                    |=> (st_q.cnt[i] == $past(st_q.cnt[i]) + CNT_W'(1)));

            // R9: decay without a hit on this counter halves it.
            p_decay_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (decay && !(inc_en && (inc_pos == POS_W'(i))))
                    |=> (st_q.cnt[i] == ($past(st_q.cnt[i]) >> 1)));
        end
    endgenerate

endmodule

// File: rtl/lru_utility_monitor.sv
module lru_utility_monitor
    import lru_umon_pkg::*;
#(
    parameter int unsigned SET_W = 11,
    parameter int unsigned TAG_W = 16,
    parameter int unsigned WAYS  = 16,
    parameter int unsigned CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [SET_W-1:0]      acc_set,
    input  logic [TAG_W-1:0]      acc_tag,
    input  logic                  decay,
    output logic [WAYS*CNT_W-1:0] hit_cnt
);
    localparam int unsigned SLOT_W = UMON_SLOT_W;
    localparam int unsigned POS_W  = $clog2(WAYS);

    logic              sampled;
    logic [SLOT_W-1:0] slot;
    acc_kind_e         kind;
    logic [POS_W-1:0]  hit_pos;

    lru_umon_sampler #(
        .SET_W  (SET_W),
        .SLOT_W (SLOT_W)
    ) u_sampler (
        .set_idx (acc_set),
        .sampled (sampled),
        .slot    (slot)
    );

    lru_umon_shadow_dir #(
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .POS_W  (POS_W)
    ) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .sampled   (sampled),
        .slot      (slot),
        .tag       (acc_tag),
        .kind      (kind),
        .hit_pos   (hit_pos)
    );

    lru_umon_hit_counters #(
        .WAYS  (WAYS),
        .CNT_W (CNT_W),
        .POS_W (POS_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (kind == ACC_HIT),
        .inc_pos  (hit_pos),
        .decay    (decay),
        .cnt_flat (hit_cnt)
    );

    // R5: cycles without a shadow hit or decay leave every counter unchanged.
    p_miss_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind != ACC_HIT) && !decay) |=> $stable(hit_cnt));

endmodule

// File: tb/lru_utility_monitor_tb.sv
module lru_utility_monitor_tb;
    localparam int SET_W = 10;
    localparam int TAG_W = 12;
    localparam int WAYS  = 16;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int NOCNT = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  acc_valid = 1'b0;
    logic [SET_W-1:0]      acc_set = '0;
    logic [TAG_W-1:0]      acc_tag = '0;
    logic                  decay = 1'b0;
    logic [WAYS*CNT_W-1:0] hit_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_cnt [WAYS];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lru_utility_monitor #(
        .SET_W (SET_W), .TAG_W (TAG_W), .WAYS (WAYS), .CNT_W (CNT_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid),
        .acc_set (acc_set), .acc_tag (acc_tag), .decay (decay),
        .hit_cnt (hit_cnt)
    );

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic [TAG_W-1:0] tag;
        logic [4:0]       code;   // 0..15 expected hit depth, 16 = no count
    } vec_t;

    // Slot 0 = set 0x000, slot 1 = 0x020, slot 31 = 0x3E0; 0x001 is unsampled.
    localparam vec_t VEC [14] = '{
        '{10'h000, 12'h001, 5'd16},  // miss, empty after reset       R1
        '{10'h000, 12'h002, 5'd16},  // miss                          R5
        '{10'h000, 12'h001, 5'd1},   // hit at depth 1                R3
        '{10'h000, 12'h001, 5'd0},   // hit at depth 0 after move     R4
        '{10'h020, 12'h001, 5'd16},  // same tag, other slot: miss    R7
        '{10'h001, 12'h003, 5'd16},  // unsampled: ignored            R2
        '{10'h000, 12'h002, 5'd1},   // depth 1 proves 0x001 ignored  R2
        '{10'h020, 12'h001, 5'd0},   // slot 1 kept its own order     R7
        '{10'h000, 12'h003, 5'd16},  // miss, third line              R5
        '{10'h000, 12'h001, 5'd2},   // rotate through depth 2        R4
        '{10'h000, 12'h002, 5'd2},
        '{10'h000, 12'h003, 5'd2},
        '{10'h3E0, 12'h005, 5'd16},  // top slot miss
        '{10'h3E0, 12'h005, 5'd0}    // top slot hit
    };

    task automatic check_cnts(input string req);
        logic [WAYS*CNT_W-1:0] expv;
        for (int i = 0; i < WAYS; i++) expv[i*CNT_W +: CNT_W] = CNT_W'(exp_cnt[i]);
        n_checks++;
        if (hit_cnt !== expv) begin
            n_fail++;
            $display("FAIL %s: hit_cnt=%h expected %h", req, hit_cnt, expv);
        end
    endtask

    // Drive one access at a falling edge; returns one cycle later, after
    // the rising edge that took it, when the counters are already updated.
    task automatic access(input logic [SET_W-1:0] s, input logic [TAG_W-1:0] t,
                          input bit with_decay);
        @(negedge clk);
        acc_valid = 1'b1; acc_set = s; acc_tag = t; decay = with_decay;
        @(negedge clk);
        acc_valid = 1'b0; decay = 1'b0;
    endtask

    task automatic expect_hit(input int p);
        if (exp_cnt[p] < CMAX) exp_cnt[p]++;
    endtask

    task automatic expect_decay();
        for (int i = 0; i < WAYS; i++) exp_cnt[i] = exp_cnt[i] >> 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WAYS; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_cnts("R1 counters zero after reset");

        // Table walk: R1 R2 R3 R4 R5 R7
        for (int k = 0; k < 14; k++) begin
            access(VEC[k].set, VEC[k].tag, 1'b0);
            if (VEC[k].code < NOCNT) expect_hit(int'(VEC[k].code));
            check_cnts($sformatf("R3/R4/R5 table vector %0d", k));
        end

        // R6: fill slot 2 with 16 distinct tags, none evicted.
        for (int t = 0; t < 16; t++) access(10'h040, TAG_W'(12'h100 + t), 1'b0);
        check_cnts("R5 fill misses leave counters");
        access(10'h040, 12'h100, 1'b0);
        expect_hit(15);
        check_cnts("R6 first of 16 tags hits at depth 15");
        access(10'h040, 12'h110, 1'b0);       // 17th tag evicts 0x101
        access(10'h040, 12'h101, 1'b0);       // must miss, evicts 0x102
        check_cnts("R6 oldest line evicted by 17th tag");
        access(10'h040, 12'h100, 1'b0);
        expect_hit(2);
        check_cnts("R4 line reached depth 2 after two inserts");
        access(10'h040, 12'h102, 1'b0);
        check_cnts("R5 dropped LRU line misses");

        // R2: same tag as a resident line but an unsampled set.
        access(10'h3E1, 12'h005, 1'b0);
        check_cnts("R2 unsampled set ignored");

        // R8: drive counter 0 to saturation and beyond.
        for (int n = 0; n < 20; n++) begin
            access(10'h3E0, 12'h005, 1'b0);
            expect_hit(0);
        end
        check_cnts("R8 counter saturates");

        // R9: decay alone halves every counter.
        @(negedge clk);
        decay = 1'b1;
        @(negedge clk);
        decay = 1'b0;
        expect_decay();
        check_cnts("R9 decay halves");

        // R10: decay together with a hit at depth 0.
        access(10'h3E0, 12'h005, 1'b1);
        expect_decay();
        expect_hit(0);
        check_cnts("R10 decay plus hit");

        // R1: reset in mid-run clears counters and invalidates the directory.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WAYS; i++) exp_cnt[i] = 0;
        check_cnts("R1 counters cleared by reset");
        access(10'h3E0, 12'h005, 1'b0);
        check_cnts("R1 directory invalid after reset");
        access(10'h3E0, 12'h005, 1'b0);
        expect_hit(0);
        check_cnts("R3 refilled line hits at depth 0");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule